// File: doc/BRIEF.md
# FEAC Codeword Serial Transmitter

This block emits the 16-bit far-end alarm and control codeword as a serial stream, one bit for each pulse on a bit-enable strobe. The stream is repeated for as long as a sending mode is selected. Two 6-bit payloads, called A and B, are stored inside the block. A 2-bit mode field chooses one of four activities: stay idle, repeat A, repeat B, or alternate between A and B word by word. While idle, the line carries a steady one.

The sequencer captures the mode and a snapshot of the payload only at a word boundary. As a result, a mode change or a payload change never cuts a word short and never corrupts a word in flight. The payload registers accept writes only while the mode field is idle, so software cannot alter a codeword while it is being repeated. An idle status output reports when no word is in progress.

Top module: `feac_tx`

## Requirements
- R1: After reset, `ser_out` is 1, `idle` is 1, the mode field is idle (00), and both payloads are 0. Entering mode 01 without any payload write therefore sends a word whose payload is 000000.
- R2: Each word is 16 bits in transmit order. Positions 0..7 are 1, position 8 is 0, positions 9..14 carry payload bits 0..5 (LSB first), and position 15 is 0.
- R3: Mode 01 repeats codeword A on every word. Mode 10 repeats codeword B on every word.
- R4: Mode 11 alternates the words A, B, A, B and so on. The first word after entering mode 11 from another mode is A.
- R5: A new mode value takes effect only at the next word boundary. The word in progress is always completed with the payload and selection it started with.
- R6: When mode 00 is selected, the word in progress is finished first. After that, `ser_out` stays at 1 and `idle` is 1. `idle` is 0 during every bit of a word.
- R7: A payload write (`pay_wr`, with `pay_sel` 0 for A and 1 for B) takes effect only when the mode field currently holds 00. In any other mode the write is ignored.
- R8: The sequencer advances one bit only on a clock edge where `bit_en` is 1. Without the strobe, `ser_out` holds its value.
- R9: Leaving idle, the first strobe still sends an idle 1 while it captures the mode. Bit 0 of the first word goes out on the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Advance the serial stream by one bit |
| mode_wr | input | 1 | Load `mode_in` into the mode field |
| mode_in | input | 2 | 00 idle, 01 repeat A, 10 repeat B, 11 alternate |
| pay_wr | input | 1 | Write `pay_in` to the selected payload |
| pay_sel | input | 1 | Payload select: 0 = A, 1 = B |
| pay_in | input | PAY_W | Payload write data |
| ser_out | output | 1 | Serial codeword bit currently on the line |
| idle | output | 1 | High when no word is in progress |

## Verification
A bit counter that slips or wraps at the wrong place shows up within one word. The fixed zeros at positions 8 and 15 then land on the wrong strobes, and the next word's run of eight ones is broken. A wrong alternation flag or a lost payload snapshot gives a wrong 6-bit field in the very next word that is loaded. A mode register that acts in the middle of a word truncates that word at the ports. A write lock that leaks shows up as a changed payload in the words that follow.

// File: rtl/feac_pkg.sv
package feac_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_A    = 2'b01,
    MODE_B    = 2'b10,
    MODE_ALT  = 2'b11
  } feac_mode_e;
endpackage

// File: rtl/feac_regs.sv
module feac_regs
  import feac_pkg::*;
#(
  parameter int unsigned PAY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [1:0]       mode_in,
  input  logic             pay_wr,
  input  logic             pay_sel,
  input  logic [PAY_W-1:0] pay_in,
  output feac_mode_e       mode_q,
  output logic [PAY_W-1:0] pay_a,
  output logic [PAY_W-1:0] pay_b
);
  // A payload write lands only while the mode field reads idle
  logic pay_unlocked;
  logic wr_a_ok;
  logic wr_b_ok;

  assign pay_unlocked = (mode_q == MODE_IDLE);
  assign wr_a_ok      = pay_wr && !pay_sel && pay_unlocked;
  assign wr_b_ok      = pay_wr &&  pay_sel && pay_unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
    end else if (mode_wr) begin
      mode_q <= feac_mode_e'(mode_in);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pay_a <= '0;
      pay_b <= '0;
    end else begin
      if (wr_a_ok) pay_a <= pay_in;
      if (wr_b_ok) pay_b <= pay_in;
    end
  end

  // R7: with a non-idle mode field, neither payload may move
  assert_pay_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_IDLE) |=> ($stable(pay_a) && $stable(pay_b)));

  // R1: the mode field changes only through an explicit write
  assert_mode_write_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode_q));
endmodule

// File: rtl/feac_seq.sv
module feac_seq
  import feac_pkg::*;
#(
  parameter int unsigned PAY_W  = 6,
  parameter int unsigned FLAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  feac_mode_e       mode_req,
  input  logic [PAY_W-1:0] pay_a,
  input  logic [PAY_W-1:0] pay_b,
  output logic             ser_out,
  output logic             idle
);
  localparam int unsigned WORD_W = FLAG_W + PAY_W + 2;
  localparam int unsigned CNT_W  = $clog2(WORD_W);
  localparam int unsigned LAST   = WORD_W - 1;

  // Line value at transmit position pos of a word carrying pay
  function automatic logic word_bit(input logic [CNT_W-1:0] pos,
                                    input logic [PAY_W-1:0] pay);
    logic b;
    b = 1'b0;
    if (pos < CNT_W'(FLAG_W)) b = 1'b1;
    for (int i = 0; i < int'(PAY_W); i++) begin
      if (pos == CNT_W'(FLAG_W + 1 + i)) b = pay[i];
    end
    return b;
  endfunction

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [PAY_W-1:0] cur_word;
  logic             cur_sel;     // 0 = A, 1 = B
  logic             alt_next_b;
  feac_mode_e       cur_mode;

  // Named events for the checks
  logic word_load;
  logic at_last;
  logic step_mid;
  logic nxt_sel;
  logic nxt_alt;

  assign at_last   = (cnt == CNT_W'(LAST));
  assign word_load = bit_en && (!running || at_last);
  assign step_mid  = bit_en && running && !at_last;

  always_comb begin
    nxt_sel = 1'b0;
    nxt_alt = 1'b0;
    case (mode_req)
      MODE_B:   nxt_sel = 1'b1;
      MODE_ALT: begin
        nxt_sel = alt_next_b;
        nxt_alt = !alt_next_b;
      end
      default:  nxt_sel = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running    <= 1'b0;
      cnt        <= '0;
      cur_word   <= '0;
      cur_sel    <= 1'b0;
      alt_next_b <= 1'b0;
      cur_mode   <= MODE_IDLE;
    end else if (word_load) begin
      cnt      <= '0;
      cur_mode <= mode_req;
      if (mode_req == MODE_IDLE) begin
        running    <= 1'b0;
        alt_next_b <= 1'b0;
      end else begin
        running    <= 1'b1;
        cur_sel    <= nxt_sel;
        alt_next_b <= nxt_alt;
        cur_word   <= nxt_sel ? pay_b : pay_a;
      end
    end else if (step_mid) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ser_out = running ? word_bit(cnt, cur_word) : 1'b1;
  assign idle    = !running;

  // R8: without a strobe the line holds
  assert_hold_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out));

  // R8: a mid-word strobe moves the position by exactly one
  assert_step_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_mid |=> (cnt == $past(cnt) + 1'b1));

  // R5: the active mode and payload are frozen inside a word
  assert_mode_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_mid |=> ($stable(cur_mode) && $stable(cur_word) && $stable(cur_sel)));

  // R4: consecutive alternate-mode words switch payload
  assert_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_load && running && cur_mode == MODE_ALT && mode_req == MODE_ALT)
      |=> (cur_sel != $past(cur_sel)));

  // R6: the status falls only as a word starts and rises only at its end
  assert_idle_edges_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !$past(word_load)) |-> !$past(idle));
endmodule

// File: rtl/feac_tx.sv
module feac_tx
  import feac_pkg::*;
#(
  parameter int unsigned PAY_W  = 6,
  parameter int unsigned FLAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             mode_wr,
  input  logic [1:0]       mode_in,
  input  logic             pay_wr,
  input  logic             pay_sel,
  input  logic [PAY_W-1:0] pay_in,
  output logic             ser_out,
  output logic             idle
);
  feac_mode_e       mode_q;
  logic [PAY_W-1:0] pay_a;
  logic [PAY_W-1:0] pay_b;

  feac_regs #(.PAY_W(PAY_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_wr (mode_wr),
    .mode_in (mode_in),
    .pay_wr  (pay_wr),
    .pay_sel (pay_sel),
    .pay_in  (pay_in),
    .mode_q  (mode_q),
    .pay_a   (pay_a),
    .pay_b   (pay_b)
  );

  feac_seq #(.PAY_W(PAY_W), .FLAG_W(FLAG_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .mode_req (mode_q),
    .pay_a    (pay_a),
    .pay_b    (pay_b),
    .ser_out  (ser_out),
    .idle     (idle)
  );

  // R6: an idle line always carries a one
  assert_idle_line_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> ser_out);
endmodule

// File: tb/tb_feac_tx.sv
module tb_feac_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       mode_wr = 1'b0;
  logic [1:0] mode_in = 2'b00;
  logic       pay_wr = 1'b0;
  logic       pay_sel = 1'b0;
  logic [5:0] pay_in = '0;
  logic       ser_out;
  logic       idle;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic  s;
    logic  i;
    string tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  feac_tx dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mode_wr(mode_wr),
    .mode_in(mode_in), .pay_wr(pay_wr), .pay_sel(pay_sel),
    .pay_in(pay_in), .ser_out(ser_out), .idle(idle)
  );

  // Word laid out as {closing 0, payload, opening 0, eight ones}; index = send order
  function automatic logic ref_bit(int k, logic [5:0] p);
    logic [15:0] w;
    w = {1'b0, p, 1'b0, 8'hFF};
    return w[k];
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // Monitor: every strobe cycle pops one expected item
  always @(negedge clk) begin
    #2;
    if (rst_n && bit_en) begin
      if (q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: strobe with no expected item, got %b expected none", ser_out);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " ser_out"}, ser_out, e.s);
        check({e.tag, " idle"}, idle, e.i);
      end
    end
  end

  task automatic quiet();
    @(negedge clk);
    bit_en = 0; mode_wr = 0; pay_wr = 0;
  endtask

  task automatic strobe(logic s, logic i, string tag);
    @(negedge clk);
    bit_en = 1; mode_wr = 0; pay_wr = 0;
    q.push_back('{s: s, i: i, tag: tag});
  endtask

  task automatic send(logic [5:0] p, int from, int to, string tag);
    for (int k = from; k <= to; k++) strobe(ref_bit(k, p), 1'b0, tag);
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk);
    bit_en = 0; pay_wr = 0; mode_wr = 1; mode_in = m;
  endtask

  task automatic write_pay(logic sel, logic [5:0] v);
    @(negedge clk);
    bit_en = 0; mode_wr = 0; pay_wr = 1; pay_sel = sel; pay_in = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] pa;
    logic [5:0] pb;
    pa = 6'h2D; pb = 6'h13;
    repeat (3) @(negedge clk);
    #3;
    check("R1 reset ser_out", ser_out, 1'b1);
    check("R1 reset idle", idle, 1'b1);
    @(negedge clk); rst_n = 1;

    // R1: payload cleared by reset, seen on the line
    set_mode(2'b01);
    strobe(1'b1, 1'b1, "R9 pickup");
    send(6'h00, 0, 3, "R1 zero payload");
    set_mode(2'b00);
    send(6'h00, 4, 15, "R1 zero payload");
    strobe(1'b1, 1'b1, "R6 idle after word");
    strobe(1'b1, 1'b1, "R6 idle after word");

    write_pay(1'b0, pa);
    write_pay(1'b1, pb);
    strobe(1'b1, 1'b1, "R6 idle strobe");

    // R3/R2: repeat A
    set_mode(2'b01);
    strobe(1'b1, 1'b1, "R9 pickup");
    send(pa, 0, 15, "R2 word A");
    send(pa, 0, 15, "R3 repeat A");
    send(pa, 0, 4, "R3 repeat A");
    set_mode(2'b10);
    write_pay(1'b0, 6'h3F);             // R7: ignored, mode field not idle
    send(pa, 5, 15, "R5 word finishes as A");
    send(pb, 0, 15, "R3 repeat B");
    send(pb, 0, 2, "R3 repeat B");
    set_mode(2'b11);
    send(pb, 3, 15, "R5 word finishes as B");
    send(pa, 0, 15, "R4 alt first A");
    send(pb, 0, 15, "R4 alt B");
    send(pa, 0, 15, "R4 alt A");
    send(pb, 0, 15, "R4 alt B");
    send(pa, 0, 6, "R7 A unchanged by locked write");
    set_mode(2'b00);
    send(pa, 7, 15, "R6 word completes before idle");
    strobe(1'b1, 1'b1, "R6 idle line");
    strobe(1'b1, 1'b1, "R6 idle line");

    // R7: write accepted while idle; R8: hold without strobe
    write_pay(1'b0, 6'h3E);
    set_mode(2'b01);
    strobe(1'b1, 1'b1, "R9 pickup");
    send(6'h3E, 0, 8, "R7 new A");
    for (int c = 0; c < 4; c++) begin
      quiet();
      #3;
      check("R8 hold without strobe", ser_out, 1'b0);
    end
    send(6'h3E, 9, 12, "R7 new A");
    set_mode(2'b00);
    send(6'h3E, 13, 15, "R7 new A");
    strobe(1'b1, 1'b1, "R6 idle line");
    quiet();
    quiet();
    if (q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: got %0d items left expected 0", q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule